// File: doc/BRIEF.md
# Paged Program Counter Address Unit

This unit produces the instruction-fetch and relative-data addresses for a small 8-bit processor. The processor has a 16-bit address space cut into sixteen pages of 4 KB each. The program counter is kept as two fields. A 12-bit offset steps forward on every fetch. A 4-bit page number moves only when it is written on purpose, so running code never leaves its own page. The fetch step happens before the fetch itself. Out of reset the counter is zero, so the first opcode is read from address 0x0001.

A relative reference adds a signed 8-bit displacement to the counter. At that moment the counter still points at the displacement byte, not at the next instruction. The sum stays in the current page.

Each bus cycle's address is held in a register. It leaves the block in two parts:
- The low 12 bits go out on dedicated lines.
- The page number goes out on the low nibble of the 8-bit data lane while the bus-phase strobe marks the address phase.
- Outside the address phase, the data lane carries the write data supplied by the processor.

Top module: `paged_pc_unit`

## Requirements
- R1: When rst_n is sampled low on a clock edge, the counter becomes 0x0000 and the address register becomes 0x0000.
- R2: A fetch command raises the low 12 bits of the counter by one. On the same edge the address register takes the new counter value, so the first fetch after reset goes to 0x0001.
- R3: A fetch from offset 0xFFF gives offset 0x000. Bits 15:12 keep their value and no carry reaches them.
- R4: A page load writes page_i into bits 15:12. The 12-bit offset and the address register keep their values.
- R5: A full load puts the whole 16-bit jump_i into the counter in one cycle and leaves the address register alone.
- R6: A displacement command loads the address register with {counter[15:12], (counter[11:0] + sign-extended disp_i) mod 4096}. The counter does not change.
- R7: A negative displacement (bit 7 of disp_i set, two's complement) and a forward sum past 0xFFF both wrap inside the current page. Bits 15:12 of the address are unchanged.
- R8: When several commands are raised together, exactly one takes effect. Priority from highest to lowest is full load, page load, displacement, fetch.
- R9: While addr_phase_i is 1, dlane_o equals {4'b0000, address register bits 15:12}. While it is 0, dlane_o equals wdata_i.
- R10: In a cycle with no command, the counter and the address register both hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_i | input | 1 | Pre-increment the offset and start a fetch address |
| page_ld_i | input | 1 | Load the page field from page_i |
| page_i | input | 4 | New page number |
| jump_ld_i | input | 1 | Load the whole counter from jump_i |
| jump_i | input | 16 | New 16-bit counter value |
| disp_ld_i | input | 1 | Load the address register with the relative address |
| disp_i | input | 8 | Signed displacement |
| addr_phase_i | input | 1 | 1 during the bus address phase |
| wdata_i | input | 8 | Write data for the data phase |
| pc_o | output | 16 | Current counter value |
| adr_lo_o | output | 12 | Address lines for bits 11:0 |
| dlane_o | output | 8 | Data lane: page nibble or write data |

## Verification
The fetch path is tested in three settings:
- from reset, to confirm the pre-increment;
- in the middle of a page, where plain counting is the only thing seen;
- at offset 0xFFF, where a wrap inside the page and a carry into the page field would give different addresses.

Displacements are tried with:
- small positive values, which show whether the base is the displacement byte's own address or the next one;
- 0x80 and 0xF0, which show whether the value is sign-extended or treated as unsigned;
- sums that go past either end of the page, which show whether the page bits stay fixed.

Combined commands and phase toggling then show which single action wins and which source drives the data lane.

// File: rtl/pcu_pkg.sv
// Package: shared command encoding for the paged counter unit.
// Assumes at most one command is acted on per cycle (chosen by the arbiter).
package pcu_pkg;
    typedef enum logic [2:0] {
        PC_IDLE  = 3'd0,
        PC_FETCH = 3'd1,
        PC_PAGE  = 3'd2,
        PC_JUMP  = 3'd3,
        PC_DISP  = 3'd4
    } pc_op_e;
endpackage

// File: rtl/pcu_cmd_arb.sv
// Module: pcu_cmd_arb
// Turns the four command strobes into one operation code.
// Assumes any mix of strobes is legal; the fixed priority picks one.
module pcu_cmd_arb
    import pcu_pkg::*;
(
    input  logic   fetch_i,
    input  logic   page_ld_i,
    input  logic   jump_ld_i,
    input  logic   disp_ld_i,
    output pc_op_e op_o
);
    // Priority pick: jump, then page, then displacement, then fetch.
    always_comb begin
        if (jump_ld_i)      op_o = PC_JUMP;
        else if (page_ld_i) op_o = PC_PAGE;
        else if (disp_ld_i) op_o = PC_DISP;
        else if (fetch_i)   op_o = PC_FETCH;
        else                op_o = PC_IDLE;
    end
endmodule

// File: rtl/pcu_counter.sv
// Module: pcu_counter
// Holds the program counter as a page field and an offset field.
// Only the offset counts; the page changes only on a page load or a jump.
// Assumes op_i is already arbitrated to a single operation.
module pcu_counter
    import pcu_pkg::*;
#(
    parameter int OFS_W = 12,
    parameter int PG_W  = 4,
    localparam int ADDR_W = OFS_W + PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pc_op_e            op_i,
    input  logic [PG_W-1:0]   page_i,
    input  logic [ADDR_W-1:0] jump_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] seq_o
);
    logic [ADDR_W-1:0] pc_q;

    // Next sequential value: the offset steps by one, the page is carried over untouched.
    always_comb begin
        seq_o = {pc_q[ADDR_W-1:OFS_W], pc_q[OFS_W-1:0] + OFS_W'(1)};
    end

    // Counter register update, one operation per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            case (op_i)
                PC_FETCH: pc_q <= seq_o;
                PC_PAGE:  pc_q[ADDR_W-1:OFS_W] <= page_i;
                PC_JUMP:  pc_q <= jump_i;
                default:  pc_q <= pc_q;
            endcase
        end
    end

    assign pc_o = pc_q;

    // R3: a fetch never changes the page field.
    p_page_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_FETCH) |=> (pc_q[ADDR_W-1:OFS_W] == $past(pc_q[ADDR_W-1:OFS_W])));

    // R3: the all-ones offset wraps to zero.
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == PC_FETCH) && (&pc_q[OFS_W-1:0])) |=> (pc_q[OFS_W-1:0] == '0));

    // R4: a page load keeps the offset.
    p_page_ofs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_PAGE) |=> (pc_q[OFS_W-1:0] == $past(pc_q[OFS_W-1:0])));

    // R5: a jump takes effect in one cycle.
    p_jump_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_JUMP) |=> (pc_q == $past(jump_i)));

    // R10: idle cycles and displacement cycles hold the counter.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == PC_IDLE) || (op_i == PC_DISP)) |=> $stable(pc_q));
endmodule

// File: rtl/pcu_rel_adder.sv
// Module: pcu_rel_adder
// Forms the relative address from the counter and a signed displacement.
// The sum is confined to the offset field; the page bits pass straight through.
// Assumes OFS_W > DISP_W.
module pcu_rel_adder #(
    parameter int OFS_W  = 12,
    parameter int PG_W   = 4,
    parameter int DISP_W = 8,
    localparam int ADDR_W = OFS_W + PG_W,
    localparam int EXT_W  = OFS_W - DISP_W
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] ea_o
);
    logic [OFS_W-1:0] disp_ext;

    // Sign-extend the displacement to the offset width.
    always_comb begin
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end

    // Add inside the page; any carry out of the offset field is dropped.
    always_comb begin
        ea_o = {base_i[ADDR_W-1:OFS_W], base_i[OFS_W-1:0] + disp_ext};
    end
endmodule

// File: rtl/pcu_bus_port.sv
// Module: pcu_bus_port
// Holds the bus address and splits it onto dedicated address lines and the data lane.
// Assumes the bus-phase strobe alone decides which source drives the data lane.
module pcu_bus_port #(
    parameter int OFS_W  = 12,
    parameter int PG_W   = 4,
    parameter int DATA_W = 8,
    localparam int ADDR_W = OFS_W + PG_W,
    localparam int PAD_W  = DATA_W - PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_phase_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [OFS_W-1:0]  adr_lo_o,
    output logic [DATA_W-1:0] dlane_o
);
    logic [ADDR_W-1:0] addr_q;

    // Bus address register, loaded on fetch and displacement cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (load_i) addr_q <= addr_i;
    end

    // Data lane mux: page nibble in the address phase, write data otherwise.
    always_comb begin
        if (addr_phase_i) dlane_o = {{PAD_W{1'b0}}, addr_q[ADDR_W-1:OFS_W]};
        else              dlane_o = wdata_i;
    end

    assign adr_lo_o = addr_q[OFS_W-1:0];
    assign addr_o   = addr_q;

    // R9: the data lane follows write data outside the address phase.
    p_lane_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_phase_i |-> (dlane_o == wdata_i));

    // R10: without a load the bus address holds.
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_q));
endmodule

// File: rtl/paged_pc_unit.sv
// Module: paged_pc_unit (top)
// Ties the arbiter, the counter, the relative adder and the bus port together.
// Assumes the command strobes are synchronous to clk; reset is synchronous, active low.
module paged_pc_unit
    import pcu_pkg::*;
#(
    parameter int OFS_W  = 12,
    parameter int PG_W   = 4,
    parameter int DISP_W = 8,
    parameter int DATA_W = 8,
    localparam int ADDR_W = OFS_W + PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_i,
    input  logic              page_ld_i,
    input  logic [PG_W-1:0]   page_i,
    input  logic              jump_ld_i,
    input  logic [ADDR_W-1:0] jump_i,
    input  logic              disp_ld_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              addr_phase_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [OFS_W-1:0]  adr_lo_o,
    output logic [DATA_W-1:0] dlane_o
);
    pc_op_e            op;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] seq;
    logic [ADDR_W-1:0] ea;
    logic [ADDR_W-1:0] bus_nxt;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_ld;

    pcu_cmd_arb u_arb (
        .fetch_i   (fetch_i),
        .page_ld_i (page_ld_i),
        .jump_ld_i (jump_ld_i),
        .disp_ld_i (disp_ld_i),
        .op_o      (op)
    );

    pcu_counter #(.OFS_W(OFS_W), .PG_W(PG_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .page_i (page_i),
        .jump_i (jump_i),
        .pc_o   (pc),
        .seq_o  (seq)
    );

    pcu_rel_adder #(.OFS_W(OFS_W), .PG_W(PG_W), .DISP_W(DISP_W)) u_rel (
        .base_i (pc),
        .disp_i (disp_i),
        .ea_o   (ea)
    );

    // Choose what the bus address register takes this cycle.
    always_comb begin
        bus_ld  = (op == PC_FETCH) || (op == PC_DISP);
        bus_nxt = (op == PC_FETCH) ? seq : ea;
    end

    pcu_bus_port #(.OFS_W(OFS_W), .PG_W(PG_W), .DATA_W(DATA_W)) u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (bus_ld),
        .addr_i       (bus_nxt),
        .addr_phase_i (addr_phase_i),
        .wdata_i      (wdata_i),
        .addr_o       (bus_addr),
        .adr_lo_o     (adr_lo_o),
        .dlane_o      (dlane_o)
    );

    assign pc_o = pc;

    // R2: after a fetch the bus address equals the new counter value.
    p_fetch_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PC_FETCH) |=> (bus_addr == pc));

    // R6: a displacement cycle keeps the counter's page in the bus address.
    p_disp_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PC_DISP) |=> (bus_addr[ADDR_W-1:OFS_W] == pc[ADDR_W-1:OFS_W]));

    // R8: at most one operation code is active, and a jump strobe always wins.
    p_jump_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        jump_ld_i |=> (pc == $past(jump_i)));
endmodule

// File: tb/paged_pc_unit_test.sv
module paged_pc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_i, page_ld_i, jump_ld_i, disp_ld_i, addr_phase_i;
    logic [3:0]  page_i;
    logic [15:0] jump_i;
    logic [7:0]  disp_i, wdata_i;
    logic [15:0] pc_o;
    logic [11:0] adr_lo_o;
    logic [7:0]  dlane_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    paged_pc_unit uut (
        .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .page_ld_i(page_ld_i),
        .page_i(page_i), .jump_ld_i(jump_ld_i), .jump_i(jump_i),
        .disp_ld_i(disp_ld_i), .disp_i(disp_i), .addr_phase_i(addr_phase_i),
        .wdata_i(wdata_i), .pc_o(pc_o), .adr_lo_o(adr_lo_o), .dlane_o(dlane_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        fetch_i = 0; page_ld_i = 0; jump_ld_i = 0; disp_ld_i = 0;
        page_i = 0; jump_i = 0; disp_i = 0;
    endtask

    // One command cycle; returns at the following falling edge, after the registers load.
    task automatic issue(input bit f, input bit pg, input logic [3:0] pv,
                         input bit j, input logic [15:0] jv, input bit d, input logic [7:0] dv);
        @(negedge clk);
        fetch_i = f; page_ld_i = pg; page_i = pv;
        jump_ld_i = j; jump_i = jv; disp_ld_i = d; disp_i = dv;
        @(negedge clk);
        idle_all();
    endtask

    // Reads the page nibble through the data lane in an address phase.
    task automatic lane_page(output logic [7:0] v);
        addr_phase_i = 1'b1; #1; v = dlane_o; addr_phase_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] lp;
        rst_n = 0; idle_all(); addr_phase_i = 0; wdata_i = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 pc", pc_o, 16'h0000);
        chk("R1 adr", {4'h0, adr_lo_o}, 16'h0000);
        lane_page(lp);
        chk("R1 lane", {8'h0, lp}, 16'h0000);
    endtask

    task automatic t_fetch();
        issue(1, 0, 0, 0, 0, 0, 0);
        chk("R2 first pc", pc_o, 16'h0001);
        chk("R2 first adr", {4'h0, adr_lo_o}, 16'h0001);
        for (int i = 0; i < 5; i++) issue(1, 0, 0, 0, 0, 0, 0);
        chk("R2 count pc", pc_o, 16'h0006);
        chk("R2 count adr", {4'h0, adr_lo_o}, 16'h0006);
    endtask

    task automatic t_idle();
        repeat (4) @(negedge clk);
        chk("R10 pc hold", pc_o, 16'h0006);
        chk("R10 adr hold", {4'h0, adr_lo_o}, 16'h0006);
    endtask

    task automatic t_page();
        logic [7:0] lp;
        issue(0, 1, 4'hA, 0, 0, 0, 0);
        chk("R4 pc", pc_o, 16'hA006);
        chk("R4 adr kept", {4'h0, adr_lo_o}, 16'h0006);
        issue(1, 0, 0, 0, 0, 0, 0);
        chk("R2 paged pc", pc_o, 16'hA007);
        lane_page(lp);
        chk("R9 lane page", {8'h0, lp}, 16'h000A);
    endtask

    task automatic t_wrap();
        logic [7:0] lp;
        issue(0, 0, 0, 1, 16'h3FFF, 0, 0);
        chk("R5 jump pc", pc_o, 16'h3FFF);
        chk("R5 adr kept", {4'h0, adr_lo_o}, 16'h0007);
        issue(1, 0, 0, 0, 0, 0, 0);
        chk("R3 wrap pc", pc_o, 16'h3000);
        chk("R3 wrap adr", {4'h0, adr_lo_o}, 16'h0000);
        lane_page(lp);
        chk("R3 wrap page", {8'h0, lp}, 16'h0003);
    endtask

    task automatic t_disp();
        logic [7:0] lp;
        issue(0, 0, 0, 1, 16'h5100, 0, 0);
        issue(0, 0, 0, 0, 0, 1, 8'h10);
        chk("R6 pos adr", {4'h0, adr_lo_o}, 16'h0110);
        chk("R6 pc kept", pc_o, 16'h5100);
        issue(0, 0, 0, 0, 0, 1, 8'h80);
        chk("R7 -128 adr", {4'h0, adr_lo_o}, 16'h0080);
        issue(0, 0, 0, 1, 16'h7005, 0, 0);
        issue(0, 0, 0, 0, 0, 1, 8'hF0);
        chk("R7 under adr", {4'h0, adr_lo_o}, 16'h0FF5);
        lane_page(lp);
        chk("R7 under page", {8'h0, lp}, 16'h0007);
        issue(0, 0, 0, 1, 16'h6FF8, 0, 0);
        issue(0, 0, 0, 0, 0, 1, 8'h0A);
        chk("R7 over adr", {4'h0, adr_lo_o}, 16'h0002);
        lane_page(lp);
        chk("R7 over page", {8'h0, lp}, 16'h0006);
    endtask

    task automatic t_prio();
        issue(1, 1, 4'h2, 1, 16'h1234, 1, 8'h01);
        chk("R8 jump wins", pc_o, 16'h1234);
        chk("R8 jump no bus", {4'h0, adr_lo_o}, 16'h0002);
        issue(1, 1, 4'h9, 0, 0, 1, 8'h01);
        chk("R8 page wins", pc_o, 16'h9234);
        chk("R8 page no bus", {4'h0, adr_lo_o}, 16'h0002);
        issue(1, 0, 0, 0, 0, 1, 8'h04);
        chk("R8 disp wins pc", pc_o, 16'h9234);
        chk("R8 disp wins adr", {4'h0, adr_lo_o}, 16'h0238);
    endtask

    task automatic t_lane();
        addr_phase_i = 0; wdata_i = 8'hC3; #1;
        chk("R9 data phase", {8'h0, dlane_o}, 16'h00C3);
        wdata_i = 8'h3C; #1;
        chk("R9 data follow", {8'h0, dlane_o}, 16'h003C);
    endtask

    initial begin
        t_reset();
        t_fetch();
        t_idle();
        t_page();
        t_wrap();
        t_disp();
        t_prio();
        t_lane();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule